// File: doc/BRIEF.md
# Strap-Loaded Converter Configuration Registers

This block holds the control settings of a two-channel digital-to-analog converter: the input-port arrangement (two ports or one interleaved port), the sample number format, the power-down byte, the output waveform mode byte, and a 10-bit gain code for each channel. A host writes and reads these settings over a four-wire serial link. The link's clock, select and data-in pins and the data-out pin are sampled by a faster system clock, which also runs the register file.

While the reset input is high, the block is in strap mode. The four serial pins are then read as static level straps, not as a link. Every register is held at its default, except the fields that a strap forces. When reset falls, the strapped values stay in place, the straps lose their meaning, and the serial link becomes the only way to change anything.

A serial frame has 16 bits and is sent most significant bit first. Each bit is sampled on a rising edge of the link clock. The first bit selects read (1) or write (0). The next seven bits are the register address, and the last eight are the data byte. The block has no streaming data path, so every pin is a plain level.

Top module: `strap_cfg_regfile`

## Requirements
- R1: While `rst` is high, every clock loads the mode register (address 0x02) with bit 6 = level of `spi_sclk`, bit 7 = level of `spi_sdi`, and bits 5:0 = 0. `single_port` shows bit 6 and `data_fmt` shows bit 7.
- R2: While `rst` is high, the output-mode register (0x0A, `out_mode`) is loaded with 0x05 if `spi_csn` is high, and with 0x00 otherwise.
- R3: While `rst` is high, the power-down register (0x03, `pwr_down`) is loaded with 0xFF if `spi_sdo_strap` is high, and with 0x00 otherwise.
- R4: While `rst` is high, both gain codes are loaded with 0x1F9.
- R5: After `rst` falls, changes on the strap pins leave every register unchanged.
- R6: A write frame (first bit 0) puts its data byte into the addressed register after the 16th rising edge of `spi_sclk`. The addresses are: 0x02 mode, 0x03 power-down, 0x0A output mode, 0x0B/0x0C channel-1 gain low byte/high bits, 0x0D/0x0E channel-2 gain low byte/high bits.
- R7: A read frame (first bit 1) shifts the addressed register's byte out on `spi_sdo`, MSB first. Each bit is valid before the rising edge of frame bits 8 to 15.
- R8: A read of any other address returns 0x00, and a write to one changes no register.
- R9: A gain high-bits address stores only data bits 1:0 and reads back bits 7:2 as zero.
- R10: A frame ended by `spi_csn` going high before 16 bits writes nothing. Bits after the 16th in a frame are ignored.
- R11: `spi_sdo_oe` is high only during the data phase of a read frame, and low while `spi_csn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link pins |
| rst | input | 1 | Active-high reset; strap mode while high |
| spi_sclk | input | 1 | Link clock; mode bit-6 strap in reset |
| spi_csn | input | 1 | Active-low frame select; mix-mode strap in reset |
| spi_sdi | input | 1 | Link data in; mode bit-7 strap in reset |
| spi_sdo_strap | input | 1 | Level sensed on the data-out pin; power-down strap in reset |
| spi_sdo | output | 1 | Link data out |
| spi_sdo_oe | output | 1 | Drive enable for the data-out pin |
| single_port | output | 1 | Mode register bit 6 |
| data_fmt | output | 1 | Mode register bit 7 |
| pwr_down | output | 8 | Power-down register |
| out_mode | output | 8 | Output waveform mode register |
| gain_ch1 | output | 10 | Channel-1 gain code |
| gain_ch2 | output | 10 | Channel-2 gain code |

## Verification
The assertions assume that `spi_csn` stays high for at least five system clocks between frames and after reset falls, so that no write can still be in flight through the synchronizer. The stimulus keeps each link clock half-period at eight system clocks and holds select high for eight clocks around every frame. The strap checks assume the strap pins are steady across the clock edge. The bench changes them only on the falling system clock edge and holds them for several cycles in reset.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int GAIN_W  = 10;
  localparam int NUM_CH  = 2;

  localparam logic [ADDR_W-1:0] A_MODE      = 7'h02;
  localparam logic [ADDR_W-1:0] A_PWR       = 7'h03;
  localparam logic [ADDR_W-1:0] A_OUTM      = 7'h0A;
  localparam logic [ADDR_W-1:0] A_GAIN_BASE = 7'h0B;

  localparam logic [GAIN_W-1:0] GAIN_DEF = 10'h1F9;
  localparam logic [DATA_W-1:0] OUTM_MIX = 8'h05;
  localparam logic [DATA_W-1:0] PWR_ALL  = 8'hFF;

  localparam int BIT_ONEPORT = 6;
  localparam int BIT_FMT     = 7;
endpackage

// File: rtl/strap_pin_sync.sv
module strap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic sdi_i,
  output logic csn_s,
  output logic sdi_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  localparam int LANES = 3;
  localparam logic [LANES-1:0] IDLE = 3'b010;

  logic [LANES-1:0] lane_q [STAGES];
  logic             sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) lane_q[0] <= IDLE;
    else     lane_q[0] <= {sdi_i, csn_i, sclk_i};
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) lane_q[s] <= IDLE;
      else     lane_q[s] <= lane_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= lane_q[STAGES-1][0];
  end

  assign csn_s     = lane_q[STAGES-1][1];
  assign sdi_s     = lane_q[STAGES-1][2];
  assign sclk_rise = lane_q[STAGES-1][0] & ~sclk_prev;
  assign sclk_fall = ~lane_q[STAGES-1][0] & sclk_prev;
endmodule

// File: rtl/strap_spi_frame.sv
module strap_spi_frame #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] C_HDR      = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] C_DAT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] C_FRAME    = CNT_W'(FRAME_BITS);
  localparam int SH_W = HDR_BITS - 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   shift_q;
  logic              is_read_q;
  logic              load_q;
  logic [DATA_W-1:0] out_sh_q;

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      cnt_q     <= '0;
      shift_q   <= '0;
      is_read_q <= 1'b0;
      load_q    <= 1'b0;
      out_sh_q  <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      reg_addr  <= '0;
    end else begin
      wr_en  <= 1'b0;
      load_q <= 1'b0;
      if (sclk_rise && cnt_q != C_FRAME) begin
        cnt_q   <= cnt_q + 1'b1;
        shift_q <= {shift_q[SH_W-2:0], sdi_s};
        if (cnt_q == C_HDR_LAST) begin
          is_read_q <= shift_q[SH_W-1];
          reg_addr  <= {shift_q[SH_W-2:0], sdi_s};
          load_q    <= 1'b1;
        end
        if (cnt_q == C_DAT_LAST && !is_read_q) begin
          wr_en   <= 1'b1;
          wr_data <= {shift_q[DATA_W-2:0], sdi_s};
        end
      end
      if (load_q) begin
        out_sh_q <= rd_data;
      end else if (sclk_fall && cnt_q > C_HDR && cnt_q < C_FRAME) begin
        out_sh_q <= {out_sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdo_oe = is_read_q && (cnt_q >= C_HDR);
  assign sdo    = sdo_oe & out_sh_q[DATA_W-1];
endmodule

// File: rtl/strap_cfg_bank.sv
module strap_cfg_bank
  import strap_cfg_pkg::*;
#(
  parameter int CH = NUM_CH,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int GW = GAIN_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strap_sclk,
  input  logic                 strap_sdi,
  input  logic                 strap_csn,
  input  logic                 strap_sdo,
  input  logic                 wr_en,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  output logic [DW-1:0]        mode_reg,
  output logic [DW-1:0]        pwr_reg,
  output logic [DW-1:0]        outm_reg,
  output logic [CH-1:0][GW-1:0] gain_reg
);
  localparam int HI_W = GW - DW;

  logic [DW-1:0] strap_mode;

  always_comb begin
    strap_mode              = '0;
    strap_mode[BIT_ONEPORT] = strap_sclk;
    strap_mode[BIT_FMT]     = strap_sdi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_reg <= strap_mode;
      pwr_reg  <= strap_sdo ? PWR_ALL : '0;
      outm_reg <= strap_csn ? OUTM_MIX : '0;
    end else if (wr_en) begin
      if (reg_addr == A_MODE) mode_reg <= wr_data;
      if (reg_addr == A_PWR)  pwr_reg  <= wr_data;
      if (reg_addr == A_OUTM) outm_reg <= wr_data;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    localparam logic [AW-1:0] LO_A = A_GAIN_BASE + AW'(2 * c);
    localparam logic [AW-1:0] HI_A = A_GAIN_BASE + AW'(2 * c + 1);
    logic [GW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= GAIN_DEF;
      end else if (wr_en && reg_addr == LO_A) begin
        q[DW-1:0] <= wr_data;
      end else if (wr_en && reg_addr == HI_A) begin
        q[GW-1:DW] <= wr_data[HI_W-1:0];
      end
    end
    assign gain_reg[c] = q;
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == A_MODE) rd_data = mode_reg;
    if (reg_addr == A_PWR)  rd_data = pwr_reg;
    if (reg_addr == A_OUTM) rd_data = outm_reg;
    for (int c = 0; c < CH; c++) begin
      if (reg_addr == A_GAIN_BASE + AW'(2 * c))
        rd_data = gain_reg[c][DW-1:0];
      if (reg_addr == A_GAIN_BASE + AW'(2 * c + 1))
        rd_data = DW'(gain_reg[c][GW-1:DW]);
    end
  end
endmodule

// File: rtl/strap_cfg_regfile.sv
module strap_cfg_regfile
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_sdi,
  input  logic              spi_sdo_strap,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              single_port,
  output logic              data_fmt,
  output logic [DATA_W-1:0] pwr_down,
  output logic [DATA_W-1:0] out_mode,
  output logic [GAIN_W-1:0] gain_ch1,
  output logic [GAIN_W-1:0] gain_ch2
);
  logic                          csn_s, sdi_s, rise, fall;
  logic                          wr_en;
  logic [ADDR_W-1:0]             reg_addr;
  logic [DATA_W-1:0]             wr_data, rd_data, mode_reg;
  logic [NUM_CH-1:0][GAIN_W-1:0] gain_reg;

  strap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sclk_i(spi_sclk), .csn_i(spi_csn), .sdi_i(spi_sdi),
    .csn_s(csn_s), .sdi_s(sdi_s), .sclk_rise(rise), .sclk_fall(fall)
  );

  strap_spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .csn_s(csn_s), .sdi_s(sdi_s),
    .sclk_rise(rise), .sclk_fall(fall), .rd_data(rd_data),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );

  strap_cfg_bank #(.CH(NUM_CH), .AW(ADDR_W), .DW(DATA_W), .GW(GAIN_W)) u_bank (
    .clk(clk), .rst(rst),
    .strap_sclk(spi_sclk), .strap_sdi(spi_sdi),
    .strap_csn(spi_csn), .strap_sdo(spi_sdo_strap),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .mode_reg(mode_reg), .pwr_reg(pwr_down), .outm_reg(out_mode),
    .gain_reg(gain_reg)
  );

  assign single_port = mode_reg[BIT_ONEPORT];
  assign data_fmt    = mode_reg[BIT_FMT];
  assign gain_ch1    = gain_reg[0];
  assign gain_ch2    = gain_reg[1];
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk (
  input logic       clk,
  input logic       rst,
  input logic       spi_sclk,
  input logic       spi_csn,
  input logic       spi_sdi,
  input logic       spi_sdo_strap,
  input logic       spi_sdo_oe,
  input logic       single_port,
  input logic       data_fmt,
  input logic [7:0] pwr_down,
  input logic [7:0] out_mode,
  input logic [9:0] gain_ch1,
  input logic [9:0] gain_ch2
);
  logic rst_q = 1'b0;
  logic sclk_q, sdi_q, csn_q, sdo_q;

  always @(posedge clk) begin
    rst_q  <= rst;
    sclk_q <= spi_sclk;
    sdi_q  <= spi_sdi;
    csn_q  <= spi_csn;
    sdo_q  <= spi_sdo_strap;
  end

  always @(negedge clk) begin
    if (rst_q) begin
      p_strap_mode_r1: assert (single_port == sclk_q && data_fmt == sdi_q);
      p_strap_mix_r2:  assert (out_mode == (csn_q ? 8'h05 : 8'h00));
      p_strap_pwr_r3:  assert (pwr_down == (sdo_q ? 8'hFF : 8'h00));
      p_gain_def_r4:   assert (gain_ch1 == 10'h1F9 && gain_ch2 == 10'h1F9);
    end
  end

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)
     && $past(spi_csn, 4) && $past(spi_csn, 5) && !$past(rst) && !$past(rst, 2))
    |-> ($stable(gain_ch1) && $stable(gain_ch2) && $stable(pwr_down)
         && $stable(out_mode) && $stable(single_port) && $stable(data_fmt)));

  p_oe_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)
     && $past(spi_csn, 4)) |-> !spi_sdo_oe);
endmodule

bind strap_cfg_regfile strap_cfg_chk u_chk (
  .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
  .spi_sdi(spi_sdi), .spi_sdo_strap(spi_sdo_strap), .spi_sdo_oe(spi_sdo_oe),
  .single_port(single_port), .data_fmt(data_fmt), .pwr_down(pwr_down),
  .out_mode(out_mode), .gain_ch1(gain_ch1), .gain_ch2(gain_ch2)
);

// File: tb/sim_strap_cfg_regfile.sv
module sim_strap_cfg_regfile;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0, spi_sdo_strap = 1'b0;
  logic spi_sdo, spi_sdo_oe, single_port, data_fmt;
  logic [7:0] pwr_down, out_mode;
  logic [9:0] gain_ch1, gain_ch2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_mode, m_pwr, m_outm;
  logic [9:0] m_g1, m_g2;

  always #10 clk = ~clk;

  strap_cfg_regfile u0 (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_sdi(spi_sdi), .spi_sdo_strap(spi_sdo_strap), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .single_port(single_port), .data_fmt(data_fmt),
    .pwr_down(pwr_down), .out_mode(out_mode), .gain_ch1(gain_ch1), .gain_ch2(gain_ch2)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    case (a)
      7'h02: return m_mode;
      7'h03: return m_pwr;
      7'h0A: return m_outm;
      7'h0B: return m_g1[7:0];
      7'h0C: return {6'b0, m_g1[9:8]};
      7'h0D: return m_g2[7:0];
      7'h0E: return {6'b0, m_g2[9:8]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [6:0] a, input logic [7:0] d);
    case (a)
      7'h02: m_mode = d;
      7'h03: m_pwr = d;
      7'h0A: m_outm = d;
      7'h0B: m_g1[7:0] = d;
      7'h0C: m_g1[9:8] = d[1:0];
      7'h0D: m_g2[7:0] = d;
      7'h0E: m_g2[9:8] = d[1:0];
      default: ;
    endcase
  endfunction

  task automatic check_ports(input string req);
    check(req, {8'h0, data_fmt, single_port, pwr_down, out_mode, gain_ch1, gain_ch2},
               {8'h0, m_mode[7], m_mode[6], m_pwr, m_outm, m_g1, m_g2});
  endtask

  task automatic spi_bits(input logic [31:0] w, input int n,
                          output logic [7:0] rd, output bit oe_ok);
    rd = 8'h00;
    oe_ok = 1'b1;
    spi_csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      int p;
      p = n - 1 - i;
      spi_sclk = 1'b0;
      spi_sdi = w[i];
      repeat (8) @(negedge clk);
      if (p >= 8 && p < 16) begin
        rd[15 - p] = spi_sdo;
        if (spi_sdo_oe !== w[n - 1]) oe_ok = 1'b0;
      end else if (p < 8 && spi_sdo_oe !== 1'b0) begin
        oe_ok = 1'b0;
      end
      spi_sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
    spi_sclk = 1'b0;
    repeat (8) @(negedge clk);
    spi_csn = 1'b1;
    repeat (8) @(negedge clk);
    if (spi_sdo_oe !== 1'b0) oe_ok = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rd;
    bit ok;
    spi_bits({16'h0, 1'b0, a, d}, 16, rd, ok);
    model_wr(a, d);
    check("R11 write oe", 64'(ok), 64'd1);
  endtask

  task automatic do_read(input logic [6:0] a, input string req);
    logic [7:0] rd;
    bit ok;
    spi_bits({16'h0, 1'b1, a, 8'h00}, 16, rd, ok);
    check(req, 64'(rd), 64'(exp_rd(a)));
    check("R11 read oe", 64'(ok), 64'd1);
  endtask

  task automatic strap_reset(input logic [3:0] s);
    rst = 1'b1;
    spi_sclk = s[0];
    spi_sdi = s[1];
    spi_csn = s[2];
    spi_sdo_strap = s[3];
    repeat (4) @(negedge clk);
    m_mode = {s[1], s[0], 6'b0};
    m_outm = s[2] ? 8'h05 : 8'h00;
    m_pwr  = s[3] ? 8'hFF : 8'h00;
    m_g1 = 10'h1F9;
    m_g2 = 10'h1F9;
    check("R1 strap mode", {data_fmt, single_port}, {s[1], s[0]});
    check("R2 strap mix", 64'(out_mode), 64'(m_outm));
    check("R3 strap pwr", 64'(pwr_down), 64'(m_pwr));
    check("R4 gain default", {gain_ch1, gain_ch2}, {10'h1F9, 10'h1F9});
    check("R11 oe in reset", 64'(spi_sdo_oe), 64'd0);
  endtask

  initial begin
    logic [6:0] pool [8];
    logic [6:0] odd [5];
    logic [7:0] rd;
    bit ok;
    pool = '{7'h02, 7'h03, 7'h0A, 7'h0B, 7'h0C, 7'h0D, 7'h0E, 7'h00};
    odd  = '{7'h00, 7'h01, 7'h04, 7'h10, 7'h7F};
    void'($urandom(32'd2024));

    for (int s = 0; s < 16; s++) strap_reset(4'(s));
    strap_reset(4'hF);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    spi_sclk = 1'b0;
    spi_sdi = 1'b0;
    spi_sdo_strap = 1'b0;
    repeat (10) @(negedge clk);
    spi_sdo_strap = 1'b1;
    spi_sdi = 1'b1;
    repeat (10) @(negedge clk);
    spi_sdi = 1'b0;
    spi_sdo_strap = 1'b0;
    repeat (10) @(negedge clk);
    check_ports("R5 straps ignored after reset");

    do_read(7'h02, "R7 read strapped mode");
    do_read(7'h0B, "R7 read gain1 low default");
    do_read(7'h0E, "R7 read gain2 high default");

    do_write(7'h0C, 8'hFF);
    check_ports("R9 gain1 high bits");
    do_read(7'h0C, "R9 gain high readback");
    do_write(7'h0D, 8'h3C);
    check_ports("R6 gain2 low write");
    do_write(7'h03, 8'h5A);
    check_ports("R6 pwr write");

    do_write(7'h7F, 8'hAA);
    check_ports("R8 unmapped write ignored");
    do_read(7'h7F, "R8 unmapped read zero");
    do_read(7'h04, "R8 unmapped read zero");

    spi_bits({16'h0, 4'h0, 1'b0, 7'h0A, 4'h3}, 12, rd, ok);
    check_ports("R10 aborted frame no write");
    spi_bits({8'h0, 1'b0, 7'h0A, 8'h81, 4'hF, 4'h0}, 24, rd, ok);
    model_wr(7'h0A, 8'h81);
    check_ports("R10 extra bits ignored");

    for (int k = 0; k < 60; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      a = pool[$urandom % 8];
      if (a == 7'h00) a = odd[$urandom % 5];
      d = 8'($urandom);
      do_write(a, d);
      check_ports("R6 random write");
      if (k % 3 == 0) do_read(pool[$urandom % 8], "R7 random read");
    end
    for (int k = 0; k < 7; k++) do_read(pool[k], "R7 sweep read");

    strap_reset(4'h0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check_ports("R1 reset restores defaults");
    do_read(7'h0D, "R4 gain2 low after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule